// File: doc/BRIEF.md
# March-Test Memory Self-Test Engine

This block tests a word-organised memory without outside help. Each memory word holds four byte lanes, and every lane is nine bits wide: eight data bits and one parity bit. When `start` is pulsed, the engine runs a three-element march over every address. It repeats the march once for each entry in a fixed table of six pattern pairs. It then applies eight word-wide patterns at address zero, which catch faults that couple neighbouring byte lanes on the data path. The engine computes every parity bit it stores. It compares all 36 bits of every word it reads back.

On the first mismatch the engine stops. It keeps the failing address, the pattern index, which phase was running, the expected word and the word actually read. It then reports `done` with `fail`. When no read miscompares, it reports `done` with `pass`.

The engine is a single state machine. Its states are: `ST_IDLE` (waiting), `ST_FILL` (write the background ascending), `ST_UP_RD`/`ST_UP_WR` (ascending read of the background, then write of the complement), `ST_DN_RD`/`ST_DN_WR` (descending read of the complement, then write of the background), `ST_BUS_WR`/`ST_BUS_RD` (bus pattern write and read-back), `ST_DRAIN` (waits for the last comparison), `ST_PASS` and `ST_FAIL`.

Its transitions are:
- start: `ST_IDLE`, `ST_PASS` or `ST_FAIL` go to `ST_FILL`.
- fill done: `ST_FILL` goes to `ST_UP_RD` at the top address.
- up done: `ST_UP_WR` goes to `ST_DN_RD` at the top address.
- next pair: `ST_DN_WR` at address 0 goes to `ST_FILL`.
- march done: `ST_DN_WR` at address 0 after the last pair goes to `ST_BUS_WR`.
- bus done: `ST_BUS_RD` after bus pattern 7 goes to `ST_DRAIN`.
- `ST_DRAIN` goes to `ST_PASS`.
- miss: any state with a mismatch goes to `ST_FAIL`. This overrides every other transition.

Top module: `mbist_march`

## Requirements
- R1: After reset, `done`, `pass` and `fail` are 0 and neither `mem_we` nor `mem_re` is high. A `start` pulse seen while idle or finished begins a new run and clears the previous result.
- R2: Let N be 2^ADDR_W. For each pattern pair the engine runs three elements, in this order and using 5N cycles in all. First it writes A at addresses 0 to N-1. Next, for addresses 0 to N-1, it reads A and then writes B at the same address in the next cycle. Last, for addresses N-1 down to 0, it reads B and then writes A.
- R3: The pattern pairs (A/B), by index, are: 0: 00000000/FFFFFFFF; 1: 0F0F0F0F/F0F0F0F0; 2: 33333333/CCCCCCCC; 3: 55555555/AAAAAAAA; 4: 007F007F/7F007F00; 5: 00007F7F/7F7F0000. They are used in index order.
- R4: Byte i of a 32-bit pattern (bits 8i+7..8i) sits at word bits 9i+7..9i. Its parity bit sits at bit 9i+8 and equals the XOR of that byte, so each nine-bit lane holds an even number of ones. The 7F bytes therefore store a parity bit of 1.
- R5: Read data is taken in the cycle after `mem_re` and compared over all 36 bits with the word expected at that address.
- R6: After the last pair, the engine writes and then reads back eight bus patterns at address 0, with no march. They are, by index: 0000FFFF, FFFF0000, 00FF00FF, FF00FF00, 0000007F, 00007F00, 007F0000, 7F000000.
- R7: On the first mismatch the engine stops all accesses and raises `done` and `fail`. It holds `fail_addr`, `fail_idx`, `fail_bus` (1 in the bus phase), `fail_exp` and `fail_act` from that read.
- R8: A run with no mismatch raises `done` and `pass` exactly 30N+17 cycles after the clock edge that samples `start`.
- R9: `mem_we` and `mem_re` are never high in the same cycle.
- R10: Once `done` is high, the result outputs hold until the next `start`. A `start` pulse during a run has no effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| start | input | 1 | Begin a run (used only when idle or finished) |
| mem_rdata | input | 36 | Read data, valid the cycle after `mem_re` |
| mem_addr | output | ADDR_W | Word address |
| mem_wdata | output | 36 | Write data, including the parity bits |
| mem_we | output | 1 | Write strobe |
| mem_re | output | 1 | Read strobe |
| done | output | 1 | Run finished |
| pass | output | 1 | Finished without a mismatch |
| fail | output | 1 | Finished on a mismatch |
| fail_bus | output | 1 | The failing read was in the bus phase |
| fail_idx | output | 3 | Pair index or bus pattern index of the failing read |
| fail_addr | output | ADDR_W | Address of the failing read |
| fail_exp | output | 36 | Expected word |
| fail_act | output | 36 | Word that was read |

## Verification
The comparison of a read always falls in the same cycle as the next step. That step is either the write that follows the read, or, after the final bus read, the drain step that would lead to a pass. The mismatch must win over both. The bench checks this with stuck bits at random addresses and positions, which end the march in the middle of an element. It also uses a fault that appears only when address 0 holds the last bus word, so the miss lands in the drain cycle. Each result is judged against a failure point that the bench predicts from the pattern table: the failing address, index, phase, expected word and read word must all match.

// File: rtl/mbist_pkg.sv
package mbist_pkg;
    localparam int LANES  = 4;
    localparam int BYTE_W = 8;
    localparam int LANE_W = BYTE_W + 1;
    localparam int DATA_W = LANES * BYTE_W;
    localparam int WORD_W = LANES * LANE_W;
    localparam int NPAIR  = 6;
    localparam int NBUS   = 8;
    localparam int IDX_W  = 3;

    typedef enum logic [3:0] {
        ST_IDLE, ST_FILL, ST_UP_RD, ST_UP_WR, ST_DN_RD, ST_DN_WR,
        ST_BUS_WR, ST_BUS_RD, ST_DRAIN, ST_PASS, ST_FAIL
    } state_e;

    // march pair table: second=0 gives background, second=1 its partner
    function automatic logic [DATA_W-1:0] march_word(input logic [IDX_W-1:0] idx,
                                                     input logic second);
        logic [DATA_W-1:0] a, b;
        case (idx)
            3'd0: begin a = 32'h0000_0000; b = 32'hFFFF_FFFF; end
            3'd1: begin a = 32'h0F0F_0F0F; b = 32'hF0F0_F0F0; end
            3'd2: begin a = 32'h3333_3333; b = 32'hCCCC_CCCC; end
            3'd3: begin a = 32'h5555_5555; b = 32'hAAAA_AAAA; end
            3'd4: begin a = 32'h007F_007F; b = 32'h7F00_7F00; end
            3'd5: begin a = 32'h0000_7F7F; b = 32'h7F7F_0000; end
            default: begin a = '0; b = '0; end
        endcase
        return second ? b : a;
    endfunction

    function automatic logic [DATA_W-1:0] bus_word(input logic [IDX_W-1:0] idx);
        case (idx)
            3'd0:    return 32'h0000_FFFF;
            3'd1:    return 32'hFFFF_0000;
            3'd2:    return 32'h00FF_00FF;
            3'd3:    return 32'hFF00_FF00;
            default: return 32'h0000_007F << (BYTE_W * (int'(idx) - 4));
        endcase
    endfunction

    // even parity per lane, parity bit on top of each nine-bit lane
    function automatic logic [WORD_W-1:0] with_parity(input logic [DATA_W-1:0] d);
        logic [WORD_W-1:0] w;
        for (int l = 0; l < LANES; l++) begin
            w[l*LANE_W +: BYTE_W]  = d[l*BYTE_W +: BYTE_W];
            w[l*LANE_W + BYTE_W]   = ^d[l*BYTE_W +: BYTE_W];
        end
        return w;
    endfunction
endpackage

// File: rtl/mbist_patgen.sv
module mbist_patgen
    import mbist_pkg::*;
(
    input  logic              bus_sel,
    input  logic [IDX_W-1:0]  idx,
    input  logic              second,
    output logic [WORD_W-1:0] word
);
    always_comb begin
        word = with_parity(bus_sel ? bus_word(idx) : march_word(idx, second));
    end
endmodule

// File: rtl/mbist_addr.sv
module mbist_addr #(
    parameter int ADDR_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr,
    input  logic              set_top,
    input  logic              inc,
    input  logic              dec,
    output logic [ADDR_W-1:0] addr,
    output logic              at_top,
    output logic              at_bot
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       addr <= '0;
        else if (clr)     addr <= '0;
        else if (set_top) addr <= '1;
        else if (inc)     addr <= addr + 1'b1;
        else if (dec)     addr <= addr - 1'b1;
    end

    assign at_top = (addr == '1);
    assign at_bot = (addr == '0);
endmodule

// File: rtl/mbist_cmp.sv
module mbist_cmp
    import mbist_pkg::*;
#(
    parameter int ADDR_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              issue,
    input  logic [WORD_W-1:0] exp_in,
    input  logic [ADDR_W-1:0] addr_in,
    input  logic [IDX_W-1:0]  idx_in,
    input  logic              bus_in,
    input  logic [WORD_W-1:0] rdata,
    output logic              miss,
    output logic [WORD_W-1:0] exp_q,
    output logic [ADDR_W-1:0] addr_q,
    output logic [IDX_W-1:0]  idx_q,
    output logic              bus_q
);
    logic             pend_q;
    logic [LANES-1:0] lane_bad;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pend_q <= 1'b0;
            exp_q  <= '0;
            addr_q <= '0;
            idx_q  <= '0;
            bus_q  <= 1'b0;
        end else begin
            pend_q <= issue;
            if (issue) begin
                exp_q  <= exp_in;
                addr_q <= addr_in;
                idx_q  <= idx_in;
                bus_q  <= bus_in;
            end
        end
    end

    for (genvar l = 0; l < LANES; l++) begin : g_lane
        assign lane_bad[l] = rdata[l*LANE_W +: LANE_W] != exp_q[l*LANE_W +: LANE_W];
    end

    assign miss = pend_q && (|lane_bad);
endmodule

// File: rtl/mbist_march.sv
module mbist_march
    import mbist_pkg::*;
#(
    parameter int ADDR_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [35:0]       mem_rdata,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [35:0]       mem_wdata,
    output logic              mem_we,
    output logic              mem_re,
    output logic              done,
    output logic              pass,
    output logic              fail,
    output logic              fail_bus,
    output logic [2:0]        fail_idx,
    output logic [ADDR_W-1:0] fail_addr,
    output logic [35:0]       fail_exp,
    output logic [35:0]       fail_act
);
    localparam logic [IDX_W-1:0] LAST_PAIR = IDX_W'(NPAIR - 1);
    localparam logic [IDX_W-1:0] LAST_BUS  = IDX_W'(NBUS - 1);

    state_e            state_q, state_n;
    logic [IDX_W-1:0]  pidx_q, bidx_q;
    logic              a_clr, a_top, a_inc, a_dec, at_top, at_bot;
    logic              p_clr, p_inc, b_clr, b_inc;
    logic              in_bus, second, miss, launch;
    logic [WORD_W-1:0] pat_word, c_exp;
    logic [ADDR_W-1:0] c_addr;
    logic [IDX_W-1:0]  cur_idx, c_idx;
    logic              c_bus;

    mbist_addr #(.ADDR_W(ADDR_W)) u_addr (
        .clk(clk), .rst_n(rst_n), .clr(a_clr), .set_top(a_top),
        .inc(a_inc), .dec(a_dec), .addr(mem_addr), .at_top(at_top), .at_bot(at_bot)
    );

    mbist_patgen u_pat (
        .bus_sel(in_bus), .idx(cur_idx), .second(second), .word(pat_word)
    );

    mbist_cmp #(.ADDR_W(ADDR_W)) u_cmp (
        .clk(clk), .rst_n(rst_n), .issue(mem_re), .exp_in(pat_word),
        .addr_in(mem_addr), .idx_in(cur_idx), .bus_in(in_bus), .rdata(mem_rdata),
        .miss(miss), .exp_q(c_exp), .addr_q(c_addr), .idx_q(c_idx), .bus_q(c_bus)
    );

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_n;
    end

    // pattern indices and captured result
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pidx_q <= '0; bidx_q <= '0;
            fail_bus <= 1'b0; fail_idx <= '0; fail_addr <= '0;
            fail_exp <= '0; fail_act <= '0;
        end else begin
            if (p_clr)      pidx_q <= '0;
            else if (p_inc) pidx_q <= pidx_q + 1'b1;
            if (b_clr)      bidx_q <= '0;
            else if (b_inc) bidx_q <= bidx_q + 1'b1;
            if (launch) begin
                fail_bus <= 1'b0; fail_idx <= '0; fail_addr <= '0;
                fail_exp <= '0; fail_act <= '0;
            end else if (miss) begin
                fail_bus <= c_bus; fail_idx <= c_idx; fail_addr <= c_addr;
                fail_exp <= c_exp; fail_act <= mem_rdata;
            end
        end
    end

    // next state
    always_comb begin
        state_n = state_q;
        a_clr = 1'b0; a_top = 1'b0; a_inc = 1'b0; a_dec = 1'b0;
        p_clr = 1'b0; p_inc = 1'b0; b_clr = 1'b0; b_inc = 1'b0;
        launch = 1'b0;
        unique case (state_q)
            ST_IDLE, ST_PASS, ST_FAIL: if (start) begin
                state_n = ST_FILL; a_clr = 1'b1; p_clr = 1'b1; launch = 1'b1;
            end
            ST_FILL: if (at_top) begin
                state_n = ST_UP_RD; a_clr = 1'b1;
            end else a_inc = 1'b1;
            ST_UP_RD: state_n = ST_UP_WR;
            ST_UP_WR: if (at_top) begin
                state_n = ST_DN_RD; a_top = 1'b1;
            end else begin
                state_n = ST_UP_RD; a_inc = 1'b1;
            end
            ST_DN_RD: state_n = ST_DN_WR;
            ST_DN_WR: if (!at_bot) begin
                state_n = ST_DN_RD; a_dec = 1'b1;
            end else if (pidx_q == LAST_PAIR) begin
                state_n = ST_BUS_WR; a_clr = 1'b1; b_clr = 1'b1;
            end else begin
                state_n = ST_FILL; a_clr = 1'b1; p_inc = 1'b1;
            end
            ST_BUS_WR: state_n = ST_BUS_RD;
            ST_BUS_RD: if (bidx_q == LAST_BUS) state_n = ST_DRAIN;
                       else begin state_n = ST_BUS_WR; b_inc = 1'b1; end
            ST_DRAIN: state_n = ST_PASS;
            default:  state_n = ST_IDLE;
        endcase
        if (miss) state_n = ST_FAIL;
    end

    // outputs decoded from state
    always_comb begin
        mem_we = 1'b0; mem_re = 1'b0; done = 1'b0; pass = 1'b0; fail = 1'b0;
        in_bus = 1'b0; second = 1'b0;
        unique case (state_q)
            ST_FILL, ST_DN_WR:   mem_we = 1'b1;
            ST_UP_WR:            begin mem_we = 1'b1; second = 1'b1; end
            ST_UP_RD:            mem_re = 1'b1;
            ST_DN_RD:            begin mem_re = 1'b1; second = 1'b1; end
            ST_BUS_WR:           begin mem_we = 1'b1; in_bus = 1'b1; end
            ST_BUS_RD:           begin mem_re = 1'b1; in_bus = 1'b1; end
            ST_PASS:             begin done = 1'b1; pass = 1'b1; end
            ST_FAIL:             begin done = 1'b1; fail = 1'b1; end
            default:             ;
        endcase
    end

    assign cur_idx   = in_bus ? bidx_q : pidx_q;
    assign mem_wdata = pat_word;
endmodule

// File: rtl/mbist_march_chk.sv
module mbist_march_chk #(
    parameter int ADDR_W = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              start,
    input logic              mem_we,
    input logic              mem_re,
    input logic              done,
    input logic              pass,
    input logic              fail,
    input logic [ADDR_W-1:0] mem_addr,
    input logic [ADDR_W-1:0] fail_addr
);
    p_excl_access_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !(mem_we && mem_re));

    p_quiet_when_done_r7: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (!mem_we && !mem_re));

    p_one_verdict_r8: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (pass != fail));

    p_hold_result_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !start) |=> (done && $stable(pass) && $stable(fail_addr)));

    p_read_then_write_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_re && !fail) |=> !mem_re);

    p_write_same_addr_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_re && !fail) |=> (fail || !mem_we || mem_addr == $past(mem_addr)));
endmodule

bind mbist_march mbist_march_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .start(start), .mem_we(mem_we), .mem_re(mem_re),
    .done(done), .pass(pass), .fail(fail), .mem_addr(mem_addr), .fail_addr(fail_addr)
);

// File: tb/mbist_march_tb.sv
`timescale 1ns/1ps
module mbist_march_tb;
    localparam int ADDR_W = 4;
    localparam int N      = 1 << ADDR_W;

    logic              clk = 1'b0, rst_n = 1'b0, start = 1'b0;
    logic [35:0]       mem_rdata, mem_wdata, fail_exp, fail_act;
    logic [ADDR_W-1:0] mem_addr, fail_addr;
    logic              mem_we, mem_re, done, pass, fail, fail_bus;
    logic [2:0]        fail_idx;

    int n_vec = 0, n_bad = 0;

    always #2.5 clk = ~clk;

    mbist_march #(.ADDR_W(ADDR_W)) u_dut (
        .clk(clk), .rst_n(rst_n), .start(start), .mem_rdata(mem_rdata),
        .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_we(mem_we), .mem_re(mem_re),
        .done(done), .pass(pass), .fail(fail), .fail_bus(fail_bus), .fail_idx(fail_idx),
        .fail_addr(fail_addr), .fail_exp(fail_exp), .fail_act(fail_act)
    );

    // memory model with injectable faults: 0 none, 1 stuck bit, 2 data-dependent flip
    logic [35:0] mem [N];
    logic [35:0] rd_q = '0;
    int          f_mode = 0, f_addr = 0, f_bit = 0;
    logic        f_val = 1'b0;
    logic [35:0] f_trig = '0;

    function automatic logic [35:0] faulty(input logic [35:0] w, input int a);
        logic [35:0] r = w;
        if (a == f_addr) begin
            if (f_mode == 1) r[f_bit] = f_val;
            if (f_mode == 2 && w == f_trig) r[f_bit] = ~w[f_bit];
        end
        return r;
    endfunction

    always @(posedge clk) begin
        if (mem_we) mem[mem_addr] <= mem_wdata;
        if (mem_re) rd_q <= faulty(mem[mem_addr], int'(mem_addr));
    end
    assign mem_rdata = rd_q;

    // reference tables (R3, R4, R6)
    function automatic logic [31:0] ref_pair(input int p, input bit s);
        logic [31:0] a[6] = '{32'h00000000, 32'h0F0F0F0F, 32'h33333333,
                              32'h55555555, 32'h007F007F, 32'h00007F7F};
        logic [31:0] b[6] = '{32'hFFFFFFFF, 32'hF0F0F0F0, 32'hCCCCCCCC,
                              32'hAAAAAAAA, 32'h7F007F00, 32'h7F7F0000};
        return s ? b[p] : a[p];
    endfunction

    function automatic logic [31:0] ref_bus(input int k);
        logic [31:0] t[8] = '{32'h0000FFFF, 32'hFFFF0000, 32'h00FF00FF, 32'hFF00FF00,
                              32'h0000007F, 32'h00007F00, 32'h007F0000, 32'h7F000000};
        return t[k];
    endfunction

    function automatic logic [35:0] ref_word(input logic [31:0] d);
        logic [35:0] w;
        for (int i = 0; i < 4; i++) begin
            w[9*i +: 8] = d[8*i +: 8];
            w[9*i + 8]  = ^d[8*i +: 8];
        end
        return w;
    endfunction

    task automatic chk(input bit ok, input string req, input logic [35:0] act,
                       input logic [35:0] exp);
        n_vec++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // expected access for cycle k after the start edge (R2, R6)
    task automatic exp_op(input int k, output bit w, output bit r, output int a,
                          output logic [35:0] d);
        w = 0; r = 0; a = 0; d = '0;
        if (k < 30*N) begin
            int p = k / (5*N), q = k % (5*N);
            if (q < N) begin w = 1; a = q; d = ref_word(ref_pair(p, 0)); end
            else if (q < 3*N) begin
                a = (q - N) / 2;
                if ((q - N) % 2 == 0) r = 1; else begin w = 1; d = ref_word(ref_pair(p, 1)); end
            end else begin
                a = N - 1 - (q - 3*N) / 2;
                if ((q - 3*N) % 2 == 0) r = 1; else begin w = 1; d = ref_word(ref_pair(p, 0)); end
            end
        end else if (k < 30*N + 16) begin
            int b = k - 30*N;
            if (b % 2 == 0) begin w = 1; d = ref_word(ref_bus(b / 2)); end
            else r = 1;
        end
    endtask

    task automatic run(input bit mon, input int pulse_at, output int cyc);
        bit ew, er; int ea; logic [35:0] ed;
        int k = 0;
        @(negedge clk) start = 1'b1;
        @(negedge clk) start = 1'b0;
        while (!done && k < 2000) begin
            if (mon) begin
                exp_op(k, ew, er, ea, ed);
                chk(mem_we == ew && mem_re == er && (!(ew || er) || int'(mem_addr) == ea)
                    && (!ew || mem_wdata == ed), k < 30*N ? "R2 march access" : "R6 bus access",
                    {mem_we, mem_re, 2'b0, 32'(mem_addr)}, {ew, er, 2'b0, 32'(ea)});
                if (ew) chk(mem_wdata == ed, "R4 write word", mem_wdata, ed);
            end
            start = (k == pulse_at);
            @(negedge clk);
            k++;
        end
        start = 1'b0;
        cyc = k;
    endtask

    // predicted first failure for a stuck bit (R7)
    task automatic predict_stuck(input int a, input int b, input bit v, output bit found,
                                 output bit bus, output int idx, output logic [35:0] e);
        found = 0; bus = 0; idx = 0; e = '0;
        for (int p = 0; p < 6 && !found; p++)
            for (int s = 0; s < 2 && !found; s++) begin
                logic [35:0] w = ref_word(ref_pair(p, s[0]));
                if (w[b] != v) begin found = 1; idx = p; e = w; end
            end
        if (a == 0)
            for (int k = 0; k < 8 && !found; k++) begin
                logic [35:0] w = ref_word(ref_bus(k));
                if (w[b] != v) begin found = 1; bus = 1; idx = k; e = w; end
            end
    endtask

    task automatic check_fail(input string req, input int a, input bit bus, input int idx,
                              input logic [35:0] e, input logic [35:0] act);
        chk(done && fail && !pass, {req, " fail flags"}, {33'b0, done, fail, pass}, 36'b110);
        chk(int'(fail_addr) == a, {req, " fail_addr"}, 36'(fail_addr), 36'(a));
        chk(fail_bus == bus && int'(fail_idx) == idx, {req, " phase/index"},
            {32'b0, fail_bus, fail_idx}, {32'b0, bus, 3'(idx)});
        chk(fail_exp == e, {req, " fail_exp"}, fail_exp, e);
        chk(fail_act == act, {req, " fail_act"}, fail_act, act);
    endtask

    initial begin
        #(5.0 * 200000);
        n_bad++;
        $display("FAIL watchdog: actual timeout expected finish");
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        int cyc;
        bit found, bus; int idx; logic [35:0] e, act;
        void'($urandom(32'h1D5EED));
        repeat (3) @(negedge clk);
        // R1 reset state
        chk(!done && !pass && !fail && !mem_we && !mem_re, "R1 reset state",
            {31'b0, done, pass, fail, mem_we, mem_re}, '0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        chk(!done && !mem_we && !mem_re, "R1 idle without start",
            {33'b0, done, mem_we, mem_re}, '0);

        // clean run with full access monitor: R2 R3 R4 R6 R8 R9
        run(1'b1, -1, cyc);
        chk(cyc == 30*N + 17, "R8 cycle count", 36'(cyc), 36'(30*N + 17));
        chk(done && pass && !fail, "R8 pass verdict", {33'b0, done, pass, fail}, 36'b110);
        repeat (5) @(negedge clk);
        chk(done && pass && !mem_we && !mem_re, "R10 hold after pass",
            {33'b0, done, pass, mem_we}, 36'b110);

        // start pulsed mid-run is ignored (R10)
        run(1'b0, 100, cyc);
        chk(cyc == 30*N + 17 && pass, "R10 start during run", 36'(cyc), 36'(30*N + 17));

        // directed: parity bit of lane 0 stuck at 0 at address 0 (R4, R7)
        f_mode = 1; f_addr = 0; f_bit = 8; f_val = 1'b0;
        run(1'b0, -1, cyc);
        e = ref_word(32'h007F007F); act = e; act[8] = 1'b0;
        check_fail("R4 parity stuck", 0, 1'b0, 4, e, act);

        // directed: fault visible only on last bus word, lands in drain cycle (R6, R7)
        f_mode = 2; f_addr = 0; f_bit = 0; f_trig = ref_word(32'h7F000000);
        run(1'b0, -1, cyc);
        act = f_trig; act[0] = ~act[0];
        check_fail("R6 last bus word", 0, 1'b1, 7, f_trig, act);

        // directed: fault at top address in background read of pair 0 (R5)
        f_mode = 1; f_addr = N - 1; f_bit = 35; f_val = 1'b1;
        run(1'b0, -1, cyc);
        e = ref_word(32'h0); act = e; act[35] = 1'b1;
        check_fail("R5 top address", N - 1, 1'b0, 0, e, act);

        // constrained random stuck bits
        for (int t = 0; t < 12; t++) begin
            f_mode = 1; f_addr = int'($urandom_range(N - 1, 0));
            f_bit = int'($urandom_range(35, 0)); f_val = 1'($urandom_range(1, 0));
            predict_stuck(f_addr, f_bit, f_val, found, bus, idx, e);
            run(1'b0, -1, cyc);
            act = e; act[f_bit] = f_val;
            if (found) check_fail("R7 random stuck", f_addr, bus, idx, e, act);
            else chk(pass, "R8 undetectable stuck", 36'(pass), 36'b1);
        end

        // restart clears a failed result (R1)
        f_mode = 0;
        run(1'b0, -1, cyc);
        chk(pass && !fail && fail_addr == '0 && fail_exp == '0, "R1 restart clears",
            fail_exp, '0);

        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule